// File: doc/BRIEF.md
# Double-Buffered Sixteen-Channel Code Register Front End

This block is the digital side of a bank of sixteen 8-bit converters. A host reaches it over a parallel bus made of a 4-bit channel address, an 8-bit data path, a select line, a read/write line, an active-low enable strobe and an active-low transfer strobe. Every channel has two registers. The first is a staging register that the host writes. The second is an output register that drives the converter code. A write changes only one staging register. Asserting the transfer strobe together with the enable strobe copies all sixteen staging registers into the output registers on one clock edge, so every converter changes at the same moment.

The block runs on a single system clock. The four control lines pass through a two-flop synchronizer, and the block acts on the synchronized levels and on the deasserting edge of the enable strobe. Address and data are sampled directly and must be held steady while a strobe is active. A reset input clears the output registers at once, with no clock edge needed. The staging registers keep their contents through reset, so a later transfer can restore the previous outputs. When the host reads, the block returns the addressed staging register on a separate read-data bus and raises an output-enable flag, which drives an external tristate buffer.

Top module: `dacbank_frontend`

## Requirements
- R1: There are sixteen channels, each with an 8-bit code. Channel n drives bits [8n+7:8n] of `dac_codes`. The address value, with bit 0 as LSB, is the channel number.
- R2: The control lines `sel_n`, `rd_wr`, `stb_n` and `xfer_n` pass through two synchronizer flops. A level that is sampled at rising edge k takes effect in the registers at rising edge k+2. Its result is therefore visible after the third rising edge that follows the change.
- R3: When `sel_n`=0, `rd_wr`=0 and `stb_n`=0 (synchronized), the staging register of the addressed channel follows `bus_wdata` on every clock. The value present in the cycle the block sees `stb_n` return high is the value kept.
- R4: Writes alone never change `dac_codes`.
- R5: While the synchronized `xfer_n` and `stb_n` are both 0, every output register is loaded from its staging register on the same edge. The outputs keep following the staging registers for as long as both strobes stay low.
- R6: While `sel_n` is 1, enable-strobe activity writes nothing. A transfer still needs only `xfer_n` and `stb_n`.
- R7: While `rst` is 1, all sixteen codes are zero. The clear takes effect as soon as `rst` rises, without waiting for a clock edge. Reset also returns the synchronizers to the idle state (all lines high).
- R8: Reset leaves the staging registers unchanged. A transfer after reset, with no new writes, restores the pre-reset codes.
- R9: When `sel_n`=0, `rd_wr`=1 and `stb_n`=0 (synchronized), `bus_rdata_oe` is 1 and `bus_rdata` holds the addressed staging register, both registered. In every other case `bus_rdata_oe` is 0.
- R10: `xfer_n` low while `stb_n` stays high transfers nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high reset; clears output codes asynchronously |
| bus_addr | input | 4 | Channel address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read-back data from the addressed staging register |
| bus_rdata_oe | output | 1 | High while read data should be driven onto the bus |
| sel_n | input | 1 | Active-low chip select |
| rd_wr | input | 1 | 1 = read, 0 = write |
| stb_n | input | 1 | Active-low enable strobe |
| xfer_n | input | 1 | Active-low transfer strobe |
| dac_codes | output | 128 | Sixteen 8-bit output codes, channel 0 in the low byte |

## Verification
The bench writes a distinct code to every channel and looks for any output that moves before the transfer. A block that leaked writes straight through to its outputs would show this. During the transfer, the bench checks that the outputs switch from all-old to all-new in one cycle and are never a mix of the two. It probes the synchronizer latency edge by edge, so one flop too few or too many shows up as an early or late update. It changes the data while the enable strobe is held low, so a block that latched on the falling edge would keep the wrong value. It strobes with the chip deselected, so a block that ignored the select would lose a staging value, and one that gated the transfer by the select would miss the load. Finally, it raises reset between clock edges and then transfers again. A synchronous clear, or one that wiped the staging registers, would fail here.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;

    localparam int unsigned CTRL_W   = 4;
    localparam int unsigned PIN_STB  = 0;
    localparam int unsigned PIN_XFER = 1;
    localparam int unsigned PIN_SEL  = 2;
    localparam int unsigned PIN_RW   = 3;
    localparam logic [CTRL_W-1:0] CTRL_IDLE = 4'b1111;

    typedef struct packed {
        logic rd;
        logic sel;
        logic xfer;
        logic stb;
    } strobe_t;

    function automatic strobe_t to_strobe(input logic [CTRL_W-1:0] p);
        strobe_t s;
        s.stb  = ~p[PIN_STB];
        s.xfer = ~p[PIN_XFER];
        s.sel  = ~p[PIN_SEL];
        s.rd   =  p[PIN_RW];
        return s;
    endfunction

    function automatic logic [15:0] onehot16(input logic [3:0] a);
        return 16'(1) << a;
    endfunction

endpackage

// File: rtl/dacbank_sync.sv
module dacbank_sync
    import dacbank_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CTRL_W-1:0] pins,
    output strobe_t           strobe,
    output logic              stb_release
);
    logic [CTRL_W-1:0] stage [STAGES];
    logic [CTRL_W-1:0] last;

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= CTRL_IDLE;
        else     stage[0] <= pins;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stage[i] <= CTRL_IDLE;
                else     stage[i] <= stage[i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last <= CTRL_IDLE;
        else     last <= stage[STAGES-1];
    end

    assign strobe      = to_strobe(stage[STAGES-1]);
    assign stb_release = stage[STAGES-1][PIN_STB] & ~last[PIN_STB];

    logic [7:0] age;
    always_ff @(posedge clk) begin
        if (rst)                age <= '0;
        else if (age < STAGES)  age <= age + 8'd1;
    end

    // R2: synchronized value equals the pin value STAGES edges earlier
    a_r2_sync_latency: assert property (@(posedge clk) disable iff (rst)
        (age >= STAGES) |-> (stage[STAGES-1] == $past(pins, STAGES)));

    // R7: reset returns the synchronizer to idle
    a_r7_sync_idle: assert property (@(posedge clk)
        $past(rst) |-> (stage[STAGES-1] == CTRL_IDLE));
endmodule

// File: rtl/dacbank_inregs.sv
module dacbank_inregs
    import dacbank_pkg::*;
#(
    parameter int unsigned CHANNELS = 16,
    parameter int unsigned CODE_W   = 8,
    localparam int unsigned ADDR_W  = $clog2(CHANNELS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  strobe_t                    strobe,
    input  logic                       stb_release,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [CODE_W-1:0]          wdata,
    output logic [CODE_W-1:0]          rdata,
    output logic                       rdata_oe,
    output logic [CHANNELS*CODE_W-1:0] staged
);
    logic [CODE_W-1:0]   stage_q [CHANNELS];
    logic                write_go;
    logic [CHANNELS-1:0] hit;

    assign write_go = ~rst & strobe.sel & ~strobe.rd & (strobe.stb | stb_release);
    assign hit      = CHANNELS'(onehot16(4'(addr)));

    generate
        for (genvar i = 0; i < CHANNELS; i++) begin : g_chan
            always_ff @(posedge clk) begin
                if (write_go && hit[i]) stage_q[i] <= wdata;
            end
            assign staged[i*CODE_W +: CODE_W] = stage_q[i];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) rdata_oe <= 1'b0;
        else     rdata_oe <= strobe.sel & strobe.rd & strobe.stb;
        rdata <= stage_q[addr];
    end

    // R9: read output enable only follows a selected read strobe
    a_r9_oe_needs_read: assert property (@(posedge clk) disable iff (rst)
        rdata_oe |-> ($past(strobe.sel) && $past(strobe.rd) && $past(strobe.stb)));

    // R6: no staging change while deselected
    a_r6_deselect_quiet: assert property (@(posedge clk) disable iff (rst)
        (!$past(strobe.sel) && !$past(rst)) |-> (staged == $past(staged)));

    // R3: a write lands the bus data in the addressed register
    a_r3_write_lands: assert property (@(posedge clk) disable iff (rst)
        $past(write_go) |-> (stage_q[$past(addr)] == $past(wdata)));
endmodule

// File: rtl/dacbank_outregs.sv
module dacbank_outregs #(
    parameter int unsigned CHANNELS = 16,
    parameter int unsigned CODE_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       load,
    input  logic [CHANNELS*CODE_W-1:0] staged,
    output logic [CHANNELS*CODE_W-1:0] codes
);
    generate
        for (genvar i = 0; i < CHANNELS; i++) begin : g_out
            always_ff @(posedge clk or posedge rst) begin
                if (rst)       codes[i*CODE_W +: CODE_W] <= '0;
                else if (load) codes[i*CODE_W +: CODE_W] <= staged[i*CODE_W +: CODE_W];
            end
        end
    endgenerate

    // R7: outputs are zero at every edge while reset is held
    a_r7_zero_in_reset: assert property (@(posedge clk)
        rst |-> (codes == '0));

    // R4: without a transfer the outputs hold
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(load)) |-> (codes == $past(codes)));

    // R5: a transfer copies every staging register on one edge
    a_r5_copy_all: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(load)) |-> (codes == $past(staged)));
endmodule

// File: rtl/dacbank_frontend.sv
module dacbank_frontend
    import dacbank_pkg::*;
#(
    parameter int unsigned CHANNELS    = 16,
    parameter int unsigned CODE_W      = 8,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned ADDR_W     = $clog2(CHANNELS),
    localparam int unsigned BUS_W      = CHANNELS * CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CODE_W-1:0] bus_wdata,
    output logic [CODE_W-1:0] bus_rdata,
    output logic              bus_rdata_oe,
    input  logic              sel_n,
    input  logic              rd_wr,
    input  logic              stb_n,
    input  logic              xfer_n,
    output logic [BUS_W-1:0]  dac_codes
);
    logic [CTRL_W-1:0] pins;
    strobe_t           strobe;
    logic              stb_release;
    logic [BUS_W-1:0]  staged;
    logic              load;

    always_comb begin
        pins           = CTRL_IDLE;
        pins[PIN_STB]  = stb_n;
        pins[PIN_XFER] = xfer_n;
        pins[PIN_SEL]  = sel_n;
        pins[PIN_RW]   = rd_wr;
    end

    dacbank_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .pins(pins),
        .strobe(strobe), .stb_release(stb_release)
    );

    dacbank_inregs #(.CHANNELS(CHANNELS), .CODE_W(CODE_W)) u_inregs (
        .clk(clk), .rst(rst), .strobe(strobe), .stb_release(stb_release),
        .addr(bus_addr), .wdata(bus_wdata),
        .rdata(bus_rdata), .rdata_oe(bus_rdata_oe), .staged(staged)
    );

    // R5 and R10: transfer needs both strobes, not the select
    assign load = strobe.xfer & strobe.stb;

    dacbank_outregs #(.CHANNELS(CHANNELS), .CODE_W(CODE_W)) u_outregs (
        .clk(clk), .rst(rst), .load(load), .staged(staged), .codes(dac_codes)
    );

    // R10: transfer strobe without enable leaves outputs alone
    a_r10_xfer_alone: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(strobe.stb)) |-> $stable(dac_codes));
endmodule

// File: tb/dacbank_frontend_bench.sv
module dacbank_frontend_bench;
    localparam int NCH = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        bus_rdata_oe;
    logic        sel_n = 1'b1, rd_wr = 1'b1, stb_n = 1'b1, xfer_n = 1'b1;
    logic [127:0] dac_codes;

    int errors = 0;
    int checks = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dacbank_frontend u_dacbank_frontend (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rdata_oe(bus_rdata_oe),
        .sel_n(sel_n), .rd_wr(rd_wr), .stb_n(stb_n), .xfer_n(xfer_n),
        .dac_codes(dac_codes)
    );

    // behavioural reference: pin history {rw, sel_n, xfer_n, stb_n}
    logic [7:0] m_in  [NCH];
    logic [7:0] m_dac [NCH];
    logic [3:0] h1 = 4'hF, h2 = 4'hF, h3 = 4'hF;
    logic       m_oe = 1'b0;
    logic [7:0] m_rd;

    always @(posedge rst) for (int i = 0; i < NCH; i++) m_dac[i] = 8'h00;

    always @(posedge clk) begin
        if (rst) begin
            h1 = 4'hF; h2 = 4'hF; h3 = 4'hF; m_oe = 1'b0;
            m_rd = m_in[bus_addr];
            for (int i = 0; i < NCH; i++) m_dac[i] = 8'h00;
        end else begin
            bit en, sl, rdn, ld, rise;
            en   = (h2[0] == 1'b0);
            ld   = (h2[1] == 1'b0);
            sl   = (h2[2] == 1'b0);
            rdn  = h2[3];
            rise = h2[0] && !h3[0];
            m_rd = m_in[bus_addr];
            m_oe = sl && rdn && en;
            if (ld && en) for (int i = 0; i < NCH; i++) m_dac[i] = m_in[i];
            if (sl && !rdn && (en || rise)) m_in[bus_addr] = bus_wdata;
            h3 = h2; h2 = h1; h1 = {rd_wr, sel_n, xfer_n, stb_n};
        end
    end

    function automatic logic [127:0] model_codes();
        logic [127:0] v;
        for (int i = 0; i < NCH; i++) v[i*8 +: 8] = m_dac[i];
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the reference
    always @(negedge clk) if (cmp_on) begin
        check(dac_codes === model_codes(), "R5 model codes", dac_codes, model_codes());
        check(bus_rdata_oe === m_oe, "R9 model oe", 128'(bus_rdata_oe), 128'(m_oe));
        if (m_oe) check(bus_rdata === m_rd, "R9 model rdata", 128'(bus_rdata), 128'(m_rd));
    end

    logic [7:0] want [NCH];

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input int ch, input logic [7:0] v, input bit selected);
        @(negedge clk);
        bus_addr = 4'(ch); bus_wdata = v; rd_wr = 1'b0;
        sel_n = !selected; stb_n = 1'b0;
        cyc(3);
        stb_n = 1'b1;
        cyc(4);
        sel_n = 1'b1; rd_wr = 1'b1;
    endtask

    task automatic bus_read(input int ch, input logic [7:0] exp, input string req);
        @(negedge clk);
        bus_addr = 4'(ch); rd_wr = 1'b1; sel_n = 1'b0; stb_n = 1'b0;
        cyc(4);
        check(bus_rdata_oe === 1'b1, req, 128'(bus_rdata_oe), 128'(1));
        check(bus_rdata === exp, req, 128'(bus_rdata), 128'(exp));
        stb_n = 1'b1;
        cyc(4);
        sel_n = 1'b1;
    endtask

    function automatic logic [127:0] want_codes();
        logic [127:0] v;
        for (int i = 0; i < NCH; i++) v[i*8 +: 8] = want[i];
        return v;
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        cmp_on = 1'b1;
        cyc(1);
        check(dac_codes === '0, "R7 reset state", dac_codes, '0);
        check(bus_rdata_oe === 1'b0, "R9 idle oe", 128'(bus_rdata_oe), 0);

        // R1/R3/R4: distinct staging values, outputs must stay at zero
        for (int i = 0; i < NCH; i++) begin
            want[i] = 8'((i * 37 + 5) ^ 8'hA0);
            bus_write(i, want[i], 1'b1);
            check(dac_codes === '0, "R4 write does not reach outputs", dac_codes, '0);
        end
        bus_read(5, want[5], "R9 read channel 5");
        bus_read(15, want[15], "R9 read channel 15");

        // R9: read strobe while deselected keeps oe low
        @(negedge clk); bus_addr = 4'd3; rd_wr = 1'b1; sel_n = 1'b1; stb_n = 1'b0;
        cyc(4);
        check(bus_rdata_oe === 1'b0, "R9 deselected read", 128'(bus_rdata_oe), 0);
        stb_n = 1'b1; cyc(4);

        // R10: transfer strobe without enable
        @(negedge clk); xfer_n = 1'b0; cyc(6);
        check(dac_codes === '0, "R10 xfer alone", dac_codes, '0);
        xfer_n = 1'b1; cyc(4);

        // R2/R5: latency and all-at-once transfer
        @(negedge clk); xfer_n = 1'b0; stb_n = 1'b0;
        cyc(1); check(dac_codes === '0, "R2 no update after edge 1", dac_codes, '0);
        cyc(1); check(dac_codes === '0, "R2 no update after edge 2", dac_codes, '0);
        cyc(1); check(dac_codes === want_codes(), "R2 R5 update after edge 3", dac_codes, want_codes());
        check(dac_codes[8*3 +: 8] === want[3], "R1 channel 3 position", 128'(dac_codes[8*3 +: 8]), 128'(want[3]));
        xfer_n = 1'b1; stb_n = 1'b1; cyc(4);

        // R6: deselected write ignored; transfer without select still works
        bus_write(2, 8'h5A, 1'b0);
        bus_read(2, want[2], "R6 deselected write ignored");
        bus_write(2, 8'hC3, 1'b1); want[2] = 8'hC3;
        @(negedge clk); sel_n = 1'b1; xfer_n = 1'b0; stb_n = 1'b0; cyc(4);
        check(dac_codes[8*2 +: 8] === 8'hC3, "R6 transfer without select", 128'(dac_codes[8*2 +: 8]), 128'(8'hC3));
        xfer_n = 1'b1; stb_n = 1'b1; cyc(4);

        // R3: data changes while enable low; last value held
        @(negedge clk); bus_addr = 4'd7; rd_wr = 1'b0; sel_n = 1'b0; stb_n = 1'b0; bus_wdata = 8'h11;
        cyc(3); bus_wdata = 8'h22; cyc(3); bus_wdata = 8'h3C; cyc(3);
        stb_n = 1'b1; cyc(4); sel_n = 1'b1; rd_wr = 1'b1; want[7] = 8'h3C;
        bus_read(7, 8'h3C, "R3 last value kept");

        // R5: outputs follow staging while both strobes held low
        @(negedge clk); xfer_n = 1'b0; bus_addr = 4'd9; bus_wdata = 8'hE7;
        rd_wr = 1'b0; sel_n = 1'b0; stb_n = 1'b0;
        cyc(6);
        check(dac_codes[8*9 +: 8] === 8'hE7, "R5 follow while held", 128'(dac_codes[8*9 +: 8]), 128'(8'hE7));
        stb_n = 1'b1; xfer_n = 1'b1; cyc(4); sel_n = 1'b1; rd_wr = 1'b1; want[9] = 8'hE7;
        cyc(2);
        check(dac_codes === want_codes(), "R5 final codes", dac_codes, want_codes());

        // R7: asynchronous clear between clock edges
        @(negedge clk); #2 rst = 1'b1; #1;
        check(dac_codes === '0, "R7 clear without clock", dac_codes, '0);
        cyc(3); @(negedge clk); rst = 1'b0; cyc(2);
        check(dac_codes === '0, "R7 zero after release", dac_codes, '0);

        // R8: staging survives reset, transfer restores outputs
        @(negedge clk); xfer_n = 1'b0; stb_n = 1'b0; cyc(4);
        check(dac_codes === want_codes(), "R8 restore after reset", dac_codes, want_codes());
        xfer_n = 1'b1; stb_n = 1'b1; cyc(4);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule